// File: doc/BRIEF.md
# Digital Loss-of-Signal Detector

This block sits behind the clock and data recovery stage of a T1/E1 receive path. It watches the recovered bit stream, taking only the cycles on which a bit-valid strobe is high. When the stream goes quiet, meaning it carries an unbroken run of zeros, it raises a digital loss-of-signal flag. The length of run that counts as quiet depends on the selected line rate.

Once the flag is up, the block stops looking at long runs. It instead evaluates the stream in back-to-back 32-bit windows, and drops the flag at the end of the first window that shows healthy ones density. The flag is combined with an analog loss-of-signal input from the line front end to form the receive loss-of-signal output. The flag also drives a select that tells the receive clock path to run from the free-running reference clock for as long as the flag is set.

Top module: `dlos_detector`

## Requirements
- R1: With `rate_cept_i` = 0 (1.544 Mb/s rate), `dlos_o` rises at the clock edge that samples the 17575th consecutive valid zero. A run of 17574 zeros followed by a one leaves it low.
- R2: With `rate_cept_i` = 1 (2.048 Mb/s rate), `dlos_o` rises at the edge that samples the 32nd consecutive valid zero. A run of 31 zeros followed by a one leaves it low.
- R3: Only cycles with `bit_vld_i` = 1 count. A valid one restarts the zero run. Cycles with `bit_vld_i` = 0 neither lengthen the run nor break it, whatever `bit_i` carries.
- R4: While `dlos_o` is high, the valid bits are grouped into non-overlapping windows of 32 bits. The first window starts with the first valid bit after the edge that raised the flag. `dlos_o` falls at the edge that samples the last bit of a window holding at least 4 ones. A window with 3 ones leaves the flag high.
- R5: A window may contain zero runs of up to 15. The 16th consecutive zero inside a window abandons that window, and a fresh window starts with the next valid bit.
- R6: `rlos_o` is high whenever `alos_i` is high or `dlos_o` is high, and low otherwise.
- R7: `clk_sel_ref_o` equals `dlos_o` on every cycle.
- R8: A change of `rate_cept_i` clears `dlos_o` and all run and window state at the next edge.
- R9: Reset (`rst_ni` low, asynchronous) and a synchronous `clr_i` pulse each leave `dlos_o` low and all counters empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of flag and counters |
| rate_cept_i | input | 1 | Line rate: 0 = 1.544 Mb/s, 1 = 2.048 Mb/s |
| bit_vld_i | input | 1 | Strobe qualifying `bit_i` |
| bit_i | input | 1 | Recovered receive bit (1 = mark) |
| alos_i | input | 1 | Analog loss-of-signal from the line front end |
| dlos_o | output | 1 | Digital loss-of-signal flag |
| rlos_o | output | 1 | Combined receive loss-of-signal |
| clk_sel_ref_o | output | 1 | Select the reference clock for the receive clock path |

## Verification
The bench drives zero runs one short of each rate's threshold and exactly at it. An off-by-one counter would fire early or late in those runs.

Recovery windows are driven with three ones and with four ones. A density test with the wrong bound would clear on three ones or stay set on four. Windows with a 15-zero run and with a 16-zero run show whether the run limit is applied at the right place. A design that did not restart the window on a 16-zero run would clear partway through the following window.

Stall cycles with a one on the data line check that the strobe gates the counters. Rate changes and clear pulses in the middle of a run check that stale counts are discarded, which a design that kept them would show by asserting after too few zeros.

// File: rtl/dlos_pkg.sv
package dlos_pkg;
  localparam int unsigned THR_T1     = 17575;
  localparam int unsigned THR_E1     = 32;
  localparam int unsigned WIN_LEN    = 32;
  localparam int unsigned WIN_ONES   = 4;
  localparam int unsigned WIN_MAXRUN = 15;

  typedef enum logic {
    RATE_T1 = 1'b0,
    RATE_E1 = 1'b1
  } rate_e;
endpackage

// File: rtl/dlos_zero_run.sv
module dlos_zero_run #(
  parameter int unsigned MAX_THR = 17575,
  localparam int unsigned CW = $clog2(MAX_THR + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          vld_i,
  input  logic          bit_i,
  input  logic [CW-1:0] thr_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (vld_i) begin
      if (bit_i)          cnt_q <= '0;
      else if (cnt_q < thr_i) cnt_q <= cnt_q + CW'(1);
    end
  end

  // current zero completes the run
  assign hit_o = vld_i & ~bit_i & (cnt_q >= (thr_i - CW'(1)));
endmodule

// File: rtl/dlos_window.sv
module dlos_window #(
  parameter int unsigned WIN      = 32,
  parameter int unsigned MIN_ONES = 4,
  parameter int unsigned MAX_RUN  = 15,
  localparam int unsigned PW = $clog2(WIN),
  localparam int unsigned OW = $clog2(MIN_ONES + 1),
  localparam int unsigned ZW = $clog2(MAX_RUN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic vld_i,
  input  logic bit_i,
  output logic good_o
);
  logic [PW-1:0] pos_q;
  logic [OW-1:0] ones_q, ones_n;
  logic [ZW-1:0] run_q, run_n;
  logic          viol, last;

  always_comb begin
    run_n  = bit_i ? '0 : run_q + ZW'(1);
    viol   = ~bit_i & (run_q == ZW'(MAX_RUN));
    ones_n = (bit_i && ones_q < OW'(MIN_ONES)) ? ones_q + OW'(1) : ones_q;
    last   = (pos_q == PW'(WIN - 1));
    good_o = vld_i & ~clr_i & ~viol & last & (ones_n >= OW'(MIN_ONES));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0; ones_q <= '0; run_q <= '0;
    end else if (clr_i) begin
      pos_q <= '0; ones_q <= '0; run_q <= '0;
    end else if (vld_i) begin
      if (viol || last) begin
        pos_q <= '0; ones_q <= '0; run_q <= '0;
      end else begin
        pos_q  <= pos_q + PW'(1);
        ones_q <= ones_n;
        run_q  <= run_n;
      end
    end
  end
endmodule

// File: rtl/dlos_detector.sv
module dlos_detector
  import dlos_pkg::*;
#(
  parameter int unsigned THR_SLOW = THR_T1,
  parameter int unsigned THR_FAST = THR_E1,
  parameter int unsigned WIN      = WIN_LEN,
  parameter int unsigned MIN_ONES = WIN_ONES,
  parameter int unsigned MAX_RUN  = WIN_MAXRUN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic rate_cept_i,
  input  logic bit_vld_i,
  input  logic bit_i,
  input  logic alos_i,
  output logic dlos_o,
  output logic rlos_o,
  output logic clk_sel_ref_o
);
  localparam int unsigned MAX_THR = (THR_SLOW > THR_FAST) ? THR_SLOW : THR_FAST;
  localparam int unsigned CW      = $clog2(MAX_THR + 1);

  rate_e         rate_q;
  logic          rate_chg, clr_all, hit, good, dlos_q;
  logic [CW-1:0] thr;

  assign rate_chg = (rate_e'(rate_cept_i) != rate_q);
  assign clr_all  = clr_i | rate_chg;
  assign thr      = rate_cept_i ? CW'(THR_FAST) : CW'(THR_SLOW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rate_q <= RATE_T1;
    else         rate_q <= rate_e'(rate_cept_i);
  end

  dlos_zero_run #(.MAX_THR(MAX_THR)) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_all),
    .vld_i  (bit_vld_i),
    .bit_i  (bit_i),
    .thr_i  (thr),
    .hit_o  (hit)
  );

  // window only runs while flagged
  dlos_window #(.WIN(WIN), .MIN_ONES(MIN_ONES), .MAX_RUN(MAX_RUN)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_all | ~dlos_q),
    .vld_i  (bit_vld_i),
    .bit_i  (bit_i),
    .good_o (good)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              dlos_q <= 1'b0;
    else if (clr_all)         dlos_q <= 1'b0;
    else if (!dlos_q && hit)  dlos_q <= 1'b1;
    else if (dlos_q && good)  dlos_q <= 1'b0;
  end

  assign dlos_o        = dlos_q;
  assign clk_sel_ref_o = dlos_q;
  assign rlos_o        = alos_i | dlos_q;
endmodule

// File: rtl/dlos_detector_chk.sv
module dlos_detector_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic clr_i,
  input logic rate_cept_i,
  input logic rate_q,
  input logic bit_vld_i,
  input logic bit_i,
  input logic alos_i,
  input logic dlos_o,
  input logic rlos_o,
  input logic clk_sel_ref_o
);
  // R1, R2: flag only rises on a sampled zero
  p_zero_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dlos_o) |-> $past(bit_vld_i && !bit_i));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_vld_i && !clr_i && (rate_cept_i == rate_q)) |=> $stable(dlos_o));

  p_fall_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dlos_o) |-> $past(bit_vld_i || clr_i || (rate_cept_i != rate_q)));

  p_alos_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alos_i |-> rlos_o);

  p_dlos_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlos_o |-> rlos_o);

  p_clk_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_ref_o == dlos_o);

  p_rate_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_cept_i != rate_q) |=> !dlos_o);

  p_sync_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !dlos_o);
endmodule

bind dlos_detector dlos_detector_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clr_i        (clr_i),
  .rate_cept_i  (rate_cept_i),
  .rate_q       (rate_q),
  .bit_vld_i    (bit_vld_i),
  .bit_i        (bit_i),
  .alos_i       (alos_i),
  .dlos_o       (dlos_o),
  .rlos_o       (rlos_o),
  .clk_sel_ref_o(clk_sel_ref_o)
);

// File: tb/sim_dlos_detector.sv
`timescale 1ns/1ps
module sim_dlos_detector;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic clr_i = 1'b0, rate_cept_i = 1'b1, bit_vld_i = 1'b0, bit_i = 1'b0, alos_i = 1'b0;
  logic dlos_o, rlos_o, clk_sel_ref_o;

  int checks = 0, errors = 0;
  logic cur_rate = 1'b1, cur_clr = 1'b0, cur_alos = 1'b0;
  logic  exp_q[$];
  logic  expr_q[$];
  string tag_q[$];
  bit    done = 1'b0;

  always #2 clk_i = ~clk_i;

  dlos_detector u0 (
    .clk_i, .rst_ni, .clr_i, .rate_cept_i, .bit_vld_i, .bit_i, .alos_i,
    .dlos_o, .rlos_o, .clk_sel_ref_o
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one cycle of stimulus plus the expected flag after its edge
  task automatic step(input logic v, input logic b, input logic e, input string t);
    @(negedge clk_i);
    bit_vld_i = v; bit_i = b;
    rate_cept_i = cur_rate; clr_i = cur_clr; alos_i = cur_alos;
    exp_q.push_back(e);
    expr_q.push_back(e | cur_alos);
    tag_q.push_back(t);
  endtask

  task automatic raise_fast(input string t);
    for (int i = 0; i < 32; i++) step(1'b1, 1'b0, (i == 31), t);
  endtask

  // monitor
  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      logic e, r;
      string t;
      e = exp_q.pop_front(); r = expr_q.pop_front(); t = tag_q.pop_front();
      chk(dlos_o, e, {t, " dlos"});
      chk(rlos_o, r, "R6 rlos");
      chk(clk_sel_ref_o, e, "R7 clk_sel");
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(dlos_o, 1'b0, "R9 reset dlos");
    chk(rlos_o, 1'b0, "R9 reset rlos");
    chk(clk_sel_ref_o, 1'b0, "R9 reset clk_sel");
    rst_ni = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b0, "R8");

    // R2 just below
    step(1'b1, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 31; i++) step(1'b1, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b1, 1'b0, "R2");
    // R3 stalls with a one on the line, then R2 hit at 32
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, "R3");
    for (int i = 0; i < 5; i++)  step(1'b0, 1'b1, 1'b0, "R3");
    for (int i = 0; i < 11; i++) step(1'b1, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b0, 1'b1, "R2");

    // R4 three ones: stays set
    for (int i = 0; i < 32; i++) step(1'b1, (i == 0 || i == 10 || i == 20), 1'b1, "R4");
    // R4 four ones: clears on last bit
    for (int i = 0; i < 32; i++) step(1'b1, (i % 8 == 0), (i != 31), "R4");
    step(1'b1, 1'b1, 1'b0, "R4");

    // R5 15-zero run allowed
    raise_fast("R2");
    for (int i = 0; i < 32; i++)
      step(1'b1, (i == 0 || i == 16 || i == 17 || i == 18), (i != 31), "R5");
    step(1'b1, 1'b1, 1'b0, "R5");

    // R5 16-zero run restarts window
    raise_fast("R2");
    for (int i = 0; i < 19; i++) step(1'b1, (i < 3), 1'b1, "R5");
    for (int i = 0; i < 32; i++) step(1'b1, (i % 8 == 0), (i != 31), "R5");
    step(1'b1, 1'b1, 1'b0, "R5");

    // R6 analog input alone
    cur_alos = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, "R6");
    cur_alos = 1'b0;
    step(1'b1, 1'b1, 1'b0, "R6");

    // R8 rate change drops the flag
    raise_fast("R2");
    cur_rate = 1'b0;
    step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b0, "R8");

    // R1 slow rate threshold
    step(1'b1, 1'b1, 1'b0, "R1");
    for (int i = 0; i < 17574; i++) step(1'b1, 1'b0, 1'b0, "R1");
    step(1'b1, 1'b1, 1'b0, "R1");
    for (int i = 0; i < 17575; i++) step(1'b1, 1'b0, (i == 17574), "R1");

    // R9 clear drops the flag
    cur_clr = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R9");
    cur_clr = 1'b0;
    step(1'b0, 1'b0, 1'b0, "R9");

    // R8 rate toggles discard a partial run
    cur_rate = 1'b1;
    step(1'b0, 1'b0, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b0, "R8");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, "R8");
    cur_rate = 1'b0; step(1'b0, 1'b0, 1'b0, "R8");
    cur_rate = 1'b1; step(1'b0, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 32; i++) step(1'b1, 1'b0, (i == 31), "R8");

    // R9 clear discards a partial run
    cur_clr = 1'b1; step(1'b0, 1'b0, 1'b0, "R9"); cur_clr = 1'b0;
    step(1'b1, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, "R9");
    cur_clr = 1'b1; step(1'b0, 1'b0, 1'b0, "R9"); cur_clr = 1'b0;
    for (int i = 0; i < 32; i++) step(1'b1, 1'b0, (i == 31), "R9");

    step(1'b0, 1'b0, 1'b1, "R3");
    repeat (4) @(negedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule